// File: doc/BRIEF.md
# Complement-Iteration Unsigned Divider

This block divides an 8-bit unsigned dividend by a 4-bit unsigned divisor without trial subtraction. With a base of 16, each pass splits the working value into a high nibble and a low nibble. The high nibble is added to the running quotient. The high nibble is also multiplied by the divisor's complement to the base (16 minus the divisor), and that product is added to the low nibble. The sum becomes the new working value. Every pass keeps `quotient * divisor + working value` equal to the dividend and makes the working value strictly smaller. The passes therefore stop once the high nibble is zero.

When the high nibble is zero but the working value is still not below the divisor, a correction cycle subtracts the divisor and adds one to the quotient. The correction repeats until the remainder is strictly smaller than the divisor. A divisor of zero is reported through a flag instead of starting any iteration.

A caller pulses `start` with the operands and then waits for the one-cycle `done` pulse. `quotient` and `remainder` stay valid until the next accepted start.

Top module: `nikhilam_div`

## Requirements
- R1: After reset, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: A start with a nonzero divisor produces one `done` pulse. At that pulse, `quotient` equals dividend / divisor, `remainder` equals dividend % divisor (both unsigned) and `div_zero` is 0.
- R3: Whenever `done` is high and `div_zero` is low, `remainder` is strictly below the divisor that was captured at start.
- R4: A start with divisor 0 raises `done` and `div_zero` on the very next clock edge, with `quotient` = 0 and `remainder` equal to the dividend.
- R5: Divisor 1 terminates with `quotient` equal to the dividend and `remainder` 0, including dividend 255.
- R6: A `start` that arrives while a division is in progress is ignored. The result delivered is the one for the operands captured first.
- R7: `quotient`, `remainder` and `div_zero` hold their values after `done` until the next accepted start.
- R8: `done` is high for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division; accepted only when idle |
| dividend | input | 8 | Unsigned dividend |
| divisor | input | 4 | Unsigned divisor |
| quotient | output | 8 | Quotient result |
| remainder | output | 8 | Remainder result (equals the dividend after a zero divisor) |
| done | output | 1 | One-cycle pulse when the results are valid |
| div_zero | output | 1 | Set when the captured divisor was zero |

## Verification
The bench builds the block with its default widths, an 8-bit dividend and a 4-bit divisor. At these widths all 4096 operand pairs can be run back to back and compared against the language's own `/` and `%`. The sweep therefore covers the slowest case, divisor 1, where the complement is 15 and the working value shrinks by only one-sixteenth per pass. It also covers every case that needs several correction cycles after the high nibble reaches zero. Directed tasks add the zero-divisor latency, a start ignored while busy, and result holding over idle cycles.

// File: rtl/nikhilam_div.sv
module nikhilam_div #(
  parameter int DW = 8,
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic [DW-1:0] remainder,
  output logic          done,
  output logic          div_zero
);
  localparam int HW = DW - VW;

  logic          busy;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] quo_q;
  logic [VW-1:0] dvs_q;

  logic [HW-1:0] hi;
  logic [VW-1:0] lo;
  logic [VW-1:0] comp;
  logic [DW-1:0] pass_rem;
  logic          has_hi;
  logic          not_below;

  assign hi        = rem_q[DW-1:VW];
  assign lo        = rem_q[VW-1:0];
  assign comp      = VW'(0) - dvs_q;
  assign pass_rem  = DW'(hi) * DW'(comp) + DW'(lo);
  assign has_hi    = |hi;
  assign not_below = rem_q >= DW'(dvs_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rem_q    <= '0;
      quo_q    <= '0;
      dvs_q    <= '0;
      done     <= 1'b0;
      div_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          rem_q <= dividend;
          quo_q <= '0;
          dvs_q <= divisor;
          if (divisor == '0) begin
            div_zero <= 1'b1;
            done     <= 1'b1;
          end else begin
            div_zero <= 1'b0;
            busy     <= 1'b1;
          end
        end
      end else if (has_hi) begin
        rem_q <= pass_rem;
        quo_q <= quo_q + DW'(hi);
      end else if (not_below) begin
        rem_q <= rem_q - DW'(dvs_q);
        quo_q <= quo_q + 1'b1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/nikhilam_div_chk.sv
module nikhilam_div_chk #(
  parameter int DW = 8,
  parameter int VW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] dividend,
  input logic          busy,
  input logic [DW-1:0] rem_q,
  input logic [DW-1:0] quo_q,
  input logic [VW-1:0] dvs_q,
  input logic          done,
  input logic          div_zero
);
  logic [DW-1:0] held_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_a <= '0;
    else if (start && !busy) held_a <= dividend;
  end

  AST_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((2*DW)'(quo_q) * (2*DW)'(dvs_q) + (2*DW)'(rem_q)) == (2*DW)'(held_a)); // R2
  AST_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || rem_q < $past(rem_q))); // R2
  AST_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> rem_q < DW'(dvs_q)); // R3
  AST_ZERO_QUO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> quo_q == '0); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R8
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(start)) |-> ($stable(rem_q) && $stable(quo_q))); // R7
endmodule

bind nikhilam_div nikhilam_div_chk #(.DW(DW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
  .busy(busy), .rem_q(rem_q), .quo_q(quo_q), .dvs_q(dvs_q),
  .done(done), .div_zero(div_zero)
);

// File: tb/nikhilam_div_tb.sv
module nikhilam_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] dividend = '0;
  logic [3:0] divisor = '0;
  logic [7:0] quotient, remainder;
  logic       done, div_zero;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nikhilam_div u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .quotient(quotient), .remainder(remainder),
    .done(done), .div_zero(div_zero)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input logic [7:0] a, input logic [3:0] b);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic one_op(input logic [7:0] a, input logic [3:0] b, input string req);
    bit ok;
    launch(a, b);
    wait_done(ok);
    check({req, " done seen"}, ok, 1);
    if (ok) begin
      if (b == 0) begin
        check({req, " R4 flag"}, div_zero, 1);
        check({req, " R4 quo"}, quotient, 0);
        check({req, " R4 rem"}, remainder, a);
      end else begin
        check({req, " R2 quo"}, quotient, a / b);
        check({req, " R2 rem"}, remainder, a % b);
        check({req, " R2 flag"}, div_zero, 0);
        check({req, " R3 rem<div"}, remainder < b, 1);
      end
      @(negedge clk);
      check({req, " R8 pulse"}, done, 0);
    end
  endtask

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 dz", div_zero, 0);
    check("R1 quo", quotient, 0);
    check("R1 rem", remainder, 0);
  endtask

  task automatic t_zero_latency();
    launch(8'd201, 4'd0);
    check("R4 done next edge", done, 1);
    check("R4 dz", div_zero, 1);
    check("R4 quo", quotient, 0);
    check("R4 rem", remainder, 201);
    @(negedge clk);
    check("R8 single cycle", done, 0);
  endtask

  task automatic t_div_one();
    one_op(8'd255, 4'd1, "R5");
    check("R5 quo", quotient, 255);
    check("R5 rem", remainder, 0);
  endtask

  task automatic t_busy_start();
    bit ok;
    launch(8'd255, 4'd1);
    @(negedge clk);
    dividend = 8'd7; divisor = 4'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check("R6 done", ok, 1);
    check("R6 quo", quotient, 255);
    check("R6 rem", remainder, 0);
    @(negedge clk);
  endtask

  task automatic t_hold();
    one_op(8'd200, 4'd7, "R7 setup");
    dividend = 8'd3; divisor = 4'd0;
    repeat (5) @(negedge clk);
    check("R7 quo held", quotient, 28);
    check("R7 rem held", remainder, 4);
    check("R7 dz held", div_zero, 0);
    check("R8 stays low", done, 0);
  endtask

  task automatic t_sweep();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 16; b++)
        one_op(8'(a), 4'(b), "R2 sweep");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_latency();
    t_div_one();
    t_busy_start();
    t_hold();
    one_op(8'd127, 4'd15, "R3 big divisor");
    one_op(8'd15, 4'd2, "R3 correction");
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc == 190000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule